// File: doc/BRIEF.md
# Self-Reloading Timer with Toggled Frequency Output

This block holds two register-programmed up-counters. Each counter starts from a value that software loads. It advances once per tick of its own clock prescaler. When it reaches its all-ones value it loads the stored start value again on its own and keeps counting. Each of these wrap events sets a sticky interrupt flag. The flag drives a request line when that counter's interrupt enable bit is set.

A toggle flip-flop changes state on each wrap of one counter, so its output frequency is half that counter's wrap rate. Two static configuration inputs decide whether the toggle reaches the shared port pin and which counter clocks it. The pin is driven only while the port direction bit selects output. The toggle reaches the pin only while the port data bit is 1. When the toggle path is disabled, the pin behaves as ordinary port I/O.

Software reaches the block through a single-cycle write strobe with address and data, and a combinational read-back at the same address. Per-timer register map (i = 0 or 1):
- Control register at address 2i.
- Start value at address 2i+1. Writing sets the start value; reading returns the live count.
- The shared flag register is at address 4.

Top module: `reload_timer_pfd`

## Requirements
- R1: While the run bit (control bit 0) is 1, the count read at address 2i+1 rises by one on each prescaler tick. While the run bit is 0, the count holds.
- R2: A tick that finds the count at 0xFF is a wrap. The count then takes the stored start value in the same step, with no software action.
- R3: The prescaler select field (control bits 3:1) holding N gives one tick every 2^N clocks while running. N = 0 ticks on every clock. The control register reads back the value written to its bits 4:0.
- R4: Writing the start value while the run bit is 0 also loads the count. While the run bit is 1, the write leaves the count alone until the next wrap loads it.
- R5: A wrap sets bit i of the flag register (address 4). The bit stays set until a write to address 4 with bit i at 1. Writing 0 to bit i has no effect, and a wrap in the same cycle wins over the clear.
- R6: `irq_o[i]` is high exactly when flag i is set and the interrupt enable (control bit 4) is 1. The counter keeps counting and setting the flag when the enable is 0.
- R7: The toggle state resets to 0. It inverts on each wrap of the timer picked by `cfg_div_src` (0 = timer 0, 1 = timer 1).
- R8: With `cfg_div_en` = 1, `pin_out` equals the toggle state when `port_data` = 1 and `port_dir` = 0. Otherwise `pin_out` is 0.
- R9: With `cfg_div_en` = 0, `pin_out` follows `port_data`. In both settings `pin_oe` is the inverse of `port_dir` (1 = input).
- R10: After reset, all registers, counts, flags, `irq_o` and `pin_out` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register address for write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_o | output | 2 | Per-timer interrupt requests |
| cfg_div_en | input | 1 | Static: route the toggle output to the pin |
| cfg_div_src | input | 1 | Static: timer whose wraps drive the toggle |
| port_data | input | 1 | Port data bit, the on/off gate for the toggle output |
| port_dir | input | 1 | Port direction bit, 1 = input |
| pin_out | output | 1 | Value driven on the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
A wrong count or prescaler phase shows up within one clock on the live count read-back. The next wrap then comes early or late, and that shifts both the flag and the toggle edge on the pin. A stale or lost start value stays hidden until the first wrap after the write. For that reason the bench keeps the count in view across several wraps after each start-value write. A flag that fails to stay set, or clears on a zero write, shows on `irq_o` and at address 4 in the cycle after the faulty write.

// File: rtl/rt_pkg.sv
// Shared constants for the reload timer: sizes and the register map.
// Assumes two timer channels, so the divider source select is one bit.
package rt_pkg;
    localparam int CNT_W      = 8;
    localparam int PSC_SEL_W  = 3;
    localparam int ADDR_W     = 3;
    localparam int NUM_TMR    = 2;
    localparam int CTRL_W     = PSC_SEL_W + 2;
    localparam int RUN_BIT    = 0;
    localparam int PSC_LSB    = 1;
    localparam int IEN_BIT    = PSC_LSB + PSC_SEL_W;
    localparam int ADR_FLAGS  = 2 * NUM_TMR;
endpackage

// File: rtl/rt_prescaler.sv
// Clock prescaler: emits one tick every 2^sel cycles while run is high.
// Assumes the phase counter restarts whenever the timer is stopped.
module rt_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PC_W = (1 << SEL_W) - 1;

    logic [PC_W-1:0] pcnt;
    logic [PC_W-1:0] mask;

    // Phase counter: free-runs while the timer runs, parked at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)   pcnt <= '0;
        else if (!run) pcnt <= '0;
        else          pcnt <= pcnt + 1'b1;
    end

    // Mask of the low sel bits; a tick occurs when they are all ones.
    always_comb begin
        for (int b = 0; b < PC_W; b++) mask[b] = (b < int'(sel));
        tick = run && ((pcnt & mask) == mask);
    end

    AST_PSC_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sel == '0) |-> tick);                                  // R3
    AST_PSC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);                                               // R1
endmodule

// File: rtl/rt_timer_chan.sv
// One timer channel: control register, start value, up-counter with
// automatic reload at all-ones, sticky wrap flag and masked request.
// Assumes writes arrive as single-cycle strobes already decoded per register.
module rt_timer_chan #(
    parameter int CNT_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             pre_wr,
    input  logic             flag_clr,
    input  logic [CNT_W-1:0] wdata,
    output logic [SEL_W+1:0] ctrl_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             flag_q,
    output logic             ovf,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] pre_q;
    logic             run;
    logic             ien;
    logic [SEL_W-1:0] sel;
    logic             tick;

    assign run = ctrl_q[0];
    assign sel = ctrl_q[SEL_W:1];
    assign ien = ctrl_q[SEL_W+1];

    rt_prescaler #(.SEL_W(SEL_W)) u_psc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .sel  (sel),
        .tick (tick)
    );

    // Control register: run bit, prescaler select and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= wdata[SEL_W+1:0];
    end

    // Start value register, consumed at the next wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_q <= '0;
        else if (pre_wr) pre_q <= wdata;
    end

    assign ovf = tick && (cnt_q == CNT_MAX);

    // Counter: direct load while stopped, else step or reload on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (pre_wr && !run) cnt_q <= wdata;
        else if (ovf)            cnt_q <= pre_q;
        else if (tick)           cnt_q <= cnt_q + 1'b1;
    end

    // Sticky wrap flag: set by a wrap, cleared by a write-one strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (ovf)      flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign irq = flag_q & ien;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q != CNT_MAX && !pre_wr) |=> cnt_q == $past(cnt_q) + 1'b1); // R1
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !pre_wr) |=> $stable(cnt_q));                         // R1
    AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> cnt_q == $past(pre_q));                                // R2
    AST_LOAD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_wr && !run) |=> cnt_q == $past(wdata));                   // R4
    AST_LOAD_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_wr && run && !tick) |=> $stable(cnt_q));                  // R4
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> flag_q);                                               // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);                             // R5
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !irq);                                                // R6
endmodule

// File: rtl/rt_divout.sv
// Divider output: toggles on each wrap of the selected timer and gates the
// result onto the port pin by the data and direction bits.
// Assumes cfg_en and src are static configuration inputs.
module rt_divout #(
    parameter int NUM   = 2,
    parameter int SRC_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM-1:0]   ovf_v,
    input  logic [SRC_W-1:0] src,
    input  logic             cfg_en,
    input  logic             port_data,
    input  logic             port_dir,
    output logic             pin_out,
    output logic             pin_oe
);
    logic tog;
    logic wrap_sel;

    assign wrap_sel = ovf_v[src];

    // Toggle flip-flop clocked by the selected timer's wraps.
    always_ff @(posedge clk) begin
        if (!rst_n)        tog <= 1'b0;
        else if (wrap_sel) tog <= ~tog;
    end

    // Pin mux: gated toggle in divider mode, plain port data otherwise.
    always_comb begin
        pin_oe  = ~port_dir;
        pin_out = cfg_en ? (tog & port_data & ~port_dir) : port_data;
    end

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_sel |=> tog != $past(tog));                               // R7
    AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_sel |=> $stable(tog));                                   // R7
    AST_FORCED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && (!port_data || port_dir)) |-> !pin_out);            // R8
    AST_PLAIN_IO: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> (pin_out == port_data));                           // R9
endmodule

// File: rtl/reload_timer_pfd.sv
// Top: two self-reloading timer channels behind a small register port,
// plus the toggled divider output on the shared pin.
// Assumes single-cycle write strobes; reads are combinational on bus_addr.
module reload_timer_pfd
    import rt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int SW = PSC_SEL_W,
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [CW-1:0]     bus_wdata,
    output logic [CW-1:0]     bus_rdata,
    output logic [NUM_TMR-1:0] irq_o,
    input  logic              cfg_div_en,
    input  logic              cfg_div_src,
    input  logic              port_data,
    input  logic              port_dir,
    output logic              pin_out,
    output logic              pin_oe
);
    localparam int CTW = SW + 2;

    logic [CTW-1:0]     ctrl_a [NUM_TMR];
    logic [CW-1:0]      cnt_a  [NUM_TMR];
    logic [NUM_TMR-1:0] flag_v;
    logic [NUM_TMR-1:0] ovf_v;

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_chan
        logic ctrl_wr, pre_wr, flag_clr;
        // Per-channel write decode.
        always_comb begin
            ctrl_wr  = bus_wr && (bus_addr == AW'(2 * g));
            pre_wr   = bus_wr && (bus_addr == AW'(2 * g + 1));
            flag_clr = bus_wr && (bus_addr == AW'(ADR_FLAGS)) && bus_wdata[g];
        end

        rt_timer_chan #(.CNT_W(CW), .SEL_W(SW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_wr (ctrl_wr),
            .pre_wr  (pre_wr),
            .flag_clr(flag_clr),
            .wdata   (bus_wdata),
            .ctrl_q  (ctrl_a[g]),
            .cnt_q   (cnt_a[g]),
            .flag_q  (flag_v[g]),
            .ovf     (ovf_v[g]),
            .irq     (irq_o[g])
        );
    end

    // Read-back mux over control, live counts and the flag register.
    always_comb begin
        bus_rdata = '0;
        for (int t = 0; t < NUM_TMR; t++) begin
            if (bus_addr == AW'(2 * t))     bus_rdata = CW'(ctrl_a[t]);
            if (bus_addr == AW'(2 * t + 1)) bus_rdata = cnt_a[t];
        end
        if (bus_addr == AW'(ADR_FLAGS)) bus_rdata = CW'(flag_v);
    end

    rt_divout #(.NUM(NUM_TMR), .SRC_W(1)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovf_v    (ovf_v),
        .src      (cfg_div_src),
        .cfg_en   (cfg_div_en),
        .port_data(port_data),
        .port_dir (port_dir),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0 && flag_v == '0));                     // R10
endmodule

// File: tb/reload_timer_pfd_test.sv
// Bench: behavioural reference model compared with the ports on every clock.
module reload_timer_pfd_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] irq_o;
    logic       cfg_div_en = 1'b0, cfg_div_src = 1'b0;
    logic       port_data = 1'b0, port_dir = 1'b0;
    logic       pin_out, pin_oe;

    reload_timer_pfd uut (.*);

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit started = 0;
    string phase = "";

    int m_cnt[2], m_pre[2], m_run[2], m_psc[2], m_ien[2], m_pc[2], m_flag[2];
    int m_tog;
    bit m_ov[2];

    // Reference model, updated at each rising edge from the driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = 0; m_pre[i] = 0; m_run[i] = 0; m_psc[i] = 0;
                m_ien[i] = 0; m_pc[i] = 0; m_flag[i] = 0;
            end
            m_tog = 0;
            started = 1;
        end else begin
            for (int i = 0; i < 2; i++) begin
                int per;
                bit tk;
                per = 1 << m_psc[i];
                tk  = (m_run[i] != 0) && ((m_pc[i] % per) == per - 1);
                m_ov[i] = tk && (m_cnt[i] == 255);
                m_pc[i] = (m_run[i] != 0) ? (m_pc[i] + 1) % 128 : 0;
                if (bus_wr && bus_addr == 2*i+1 && m_run[i] == 0) m_cnt[i] = bus_wdata;
                else if (m_ov[i]) m_cnt[i] = m_pre[i];
                else if (tk) m_cnt[i] = m_cnt[i] + 1;
                if (m_ov[i]) m_flag[i] = 1;
                else if (bus_wr && bus_addr == 4 && bus_wdata[i]) m_flag[i] = 0;
                if (bus_wr && bus_addr == 2*i+1) m_pre[i] = bus_wdata;
                if (bus_wr && bus_addr == 2*i) begin
                    m_run[i] = bus_wdata[0];
                    m_psc[i] = bus_wdata[3:1];
                    m_ien[i] = bus_wdata[4];
                end
            end
            if (m_ov[cfg_div_src]) m_tog = 1 - m_tog;
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s%s: actual %h expected %h at %0t", phase, tag, act, exp, $time);
        end
    endtask

    // Compare on every falling edge, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            logic [7:0] e_rd;
            logic [1:0] e_irq;
            logic [1:0] e_pin;
            string rtag;
            case (bus_addr)
                3'd0, 3'd2: begin
                    e_rd = 8'(m_ien[bus_addr/2]*16 + m_psc[bus_addr/2]*2 + m_run[bus_addr/2]);
                    rtag = "R3 control read";
                end
                3'd1, 3'd3: begin
                    e_rd = 8'(m_cnt[bus_addr/2]);
                    rtag = "R1 R2 R4 count read";
                end
                3'd4: begin
                    e_rd = 8'(m_flag[1]*2 + m_flag[0]);
                    rtag = "R5 flag read";
                end
                default: begin
                    e_rd = 8'h00;
                    rtag = "unmapped read";
                end
            endcase
            chk(rtag, bus_rdata, e_rd);
            e_irq = {1'(m_flag[1] & m_ien[1]), 1'(m_flag[0] & m_ien[0])};
            chk("R6 irq", {6'd0, irq_o}, {6'd0, e_irq});
            e_pin[1] = ~port_dir;
            e_pin[0] = cfg_div_en ? (1'(m_tog) & port_data & ~port_dir) : port_data;
            chk(cfg_div_en ? "R7 R8 pin" : "R9 pin", {6'd0, pin_oe, pin_out}, {6'd0, e_pin});
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic look(logic [2:0] a);
        @(negedge clk); #1;
        bus_addr = a;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Watchdog: an overrun counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R10: reset values at every address, during and after reset.
        phase = "R10 ";
        idle(3);
        for (int a = 0; a < 5; a++) look(3'(a));
        @(negedge clk); #1; rst_n = 1'b1;
        for (int a = 0; a < 5; a++) look(3'(a));
        phase = "";
        cfg_div_en = 1; cfg_div_src = 0; port_data = 1; port_dir = 0;

        // R4 stopped load, then R1 R2 R3 run with no prescale, R7 toggles.
        wr(3'd1, 8'hF0);
        look(3'd1); idle(2);
        wr(3'd0, 8'h11);
        look(3'd1); idle(40);
        // R5: zero write ignored, one write clears.
        wr(3'd4, 8'h00); look(3'd4); idle(2);
        wr(3'd4, 8'h01); look(3'd4); idle(2);
        // R6: enable off, counting and flag continue, request stays low.
        wr(3'd0, 8'h01); look(3'd4); idle(40);
        // R4: start value written while running takes effect at next wrap.
        wr(3'd1, 8'h80); look(3'd1); idle(300);
        wr(3'd4, 8'h03);

        // Timer 1 with prescale 8, toggle source switched to it.
        wr(3'd3, 8'hFA);
        wr(3'd2, 8'h17);
        cfg_div_src = 1;
        look(3'd3); idle(200);
        look(3'd2); idle(2);

        // R8 gating and R9 plain I/O.
        port_data = 0; idle(20);
        port_data = 1; port_dir = 1; idle(20);
        port_dir = 0; idle(20);
        cfg_div_en = 0; idle(10);
        port_data = 0; idle(10);
        port_dir = 1; idle(10);
        port_dir = 0; port_data = 1; cfg_div_en = 1;

        // R1 hold while stopped, R4 direct load, R3 prescale 128.
        wr(3'd0, 8'h10); look(3'd1); idle(30);
        wr(3'd1, 8'h33); look(3'd1); idle(5);
        wr(3'd2, 8'h1F); look(3'd3); idle(1700);
        look(3'd4); idle(4);
        // Clear with a wrap pending, then a reset in mid-run.
        wr(3'd4, 8'h02); idle(4);
        phase = "R10 ";
        @(negedge clk); #1; rst_n = 1'b0;
        idle(2);
        @(negedge clk); #1; rst_n = 1'b1;
        for (int a = 0; a < 5; a++) look(3'(a));
        phase = "";
        idle(2);
        summary();
        $finish;
    end
endmodule